// File: doc/BRIEF.md
# Cellular Automaton Pixel Fetch

This block connects a raster video timing generator to a frame memory that holds the rows of a one-dimensional cellular automaton, one bit per cell, one memory row per generation. For every pixel coordinate the timing generator presents, the block forms a row-major memory address, takes the returned cell bit, and produces an RGB colour. Live cells are tinted by a hue picked from the generation (row) number. Dead cells and coordinates outside the active picture are black.

The colour follows a fixed contract. Coordinates change after a rising clock edge. The colour is worked out during that cycle and appears on the RGB outputs after the next rising edge, where the timing generator registers it one edge later. The contract leaves no spare edge for a synchronous memory, so the block is built in one of two fetch modes. In direct mode the address comes from the coordinates now on the inputs, and the memory answers within the same cycle. In ahead mode the address belongs to the raster successor of the current coordinates, so that a memory with one cycle of read latency returns the bit just as that successor coordinate arrives. In ahead mode the block tracks its own prediction and blanks any pixel whose prefetch missed.

Top module: `ca_pixel_fetch`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `red`, `green` and `blue` are all zero.
- R2: The colour for the coordinates presented in cycle n appears on the RGB outputs in cycle n+1 (one rising edge later) and holds for exactly that cycle.
- R3: In direct mode, for an active coordinate, `mem_addr` equals `pix_y*COLS + pix_x` combinationally in the same cycle, and `mem_data` is sampled at the end of that cycle.
- R4: A coordinate with `pix_x >= COLS` or `pix_y >= ROWS` yields black. The address formed for such a coordinate is 0.
- R5: An active pixel whose cell bit is 0 yields black.
- R6: A live active pixel takes hue entry k = `pix_y mod 2^HUE_BITS`. With N = 2^HUE_BITS and M = 2^CW-1, let h = floor(k*6*M/N), s = h/M and f = h mod M. Then (R,G,B) is (M,f,0), (M-f,M,0), (0,M,f), (0,M-f,M), (f,0,M) or (M,0,M-f) for s = 0 to 5. With the defaults (HUE_BITS=2, CW=4) the entries are 0xF00, 0x8F0, 0x0FF and 0x70F as {R,G,B}.
- R7: In ahead mode, `mem_addr` is the address of the raster successor of the current coordinates. The successor is (x+1,y), or (0,y+1) when x = H_TOTAL-1, or (0,0) when also y = V_TOTAL-1. The bit that returns on `mem_data` in the next cycle is used for the pixel presented in that cycle.
- R8: In ahead mode, a pixel is black when its coordinates are not the successor of the previous cycle's coordinates, and also on the first cycle after reset.
- R9: `mem_addr` is always below COLS*ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | XW | Column coordinate from the timing generator |
| pix_y | input | YW | Row (generation) coordinate from the timing generator |
| mem_addr | output | AW | Cell address to the frame memory |
| mem_data | input | 1 | Cell bit returned by the frame memory |
| red | output | CW | Red channel to the timing generator |
| green | output | CW | Green channel to the timing generator |
| blue | output | CW | Blue channel to the timing generator |

## Verification
The bench builds two copies with the default geometry: a 16x12 active area inside a 20x15 raster, four hue entries and 4-bit channels. One copy is in direct mode with a combinational memory model. The other is in ahead mode with a registered memory model. The small raster lets full frames run, including the line wrap, the frame wrap and the blanking columns and rows, so R4, R7 and the wrap cases of the successor are all reached many times. Random coordinate jumps and a reset in the middle of a scan drive the ahead copy through its miss path (R8).

// File: rtl/ca_fetch_pkg.sv
// Shared definitions for the cellular-automaton pixel fetch block.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ca_fetch_pkg;

    // Fetch mode: address from the current coordinate, or from the predicted next one
    typedef enum logic {
        FETCH_DIRECT = 1'b0,
        FETCH_AHEAD  = 1'b1
    } fetch_mode_e;

endpackage

// File: rtl/ca_raster_next.sv
// Works out the raster successor of a coordinate: the next column on the same
// line, the start of the next line, or the origin after the last line.
// Assumes: the coordinate lies inside the H_TOTAL x V_TOTAL raster.
module ca_raster_next #(
    parameter int H_TOTAL = 20,
    parameter int V_TOTAL = 15,
    parameter int XW      = 5,
    parameter int YW      = 4
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    output logic [XW-1:0] nxt_x,
    output logic [YW-1:0] nxt_y
);

    logic line_end;
    logic frame_end;

    // Step one position along the raster, wrapping at line and frame ends
    always_comb begin
        line_end  = (int'(cur_x) == H_TOTAL - 1);
        frame_end = (int'(cur_y) == V_TOTAL - 1);
        if (line_end) begin
            nxt_x = '0;
            nxt_y = frame_end ? '0 : cur_y + YW'(1);
        end else begin
            nxt_x = cur_x + XW'(1);
            nxt_y = cur_y;
        end
    end

endmodule

// File: rtl/ca_row_addr.sv
// Maps a coordinate to a row-major cell address (row * COLS + column).
// Outside the active area the address is forced to 0, so it always stays in range.
// Assumes: COLS*ROWS fits in AW bits.
module ca_row_addr #(
    parameter int COLS = 16,
    parameter int ROWS = 12,
    parameter int XW   = 5,
    parameter int YW   = 4,
    parameter int AW   = 8
) (
    input  logic [XW-1:0] at_x,
    input  logic [YW-1:0] at_y,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] ROW_STRIDE = AW'(COLS);

    logic in_area;

    // Row-major address for active coordinates, zero elsewhere
    always_comb begin
        in_area = (int'(at_x) < COLS) && (int'(at_y) < ROWS);
        if (in_area) begin
            addr = AW'(at_y) * ROW_STRIDE + AW'(at_x);
        end else begin
            addr = '0;
        end
    end

endmodule

// File: rtl/ca_pred_track.sv
// Remembers the coordinate whose cell bit was requested one cycle earlier and
// reports whether the coordinate now presented is that one.
// Assumes: the frame memory returns data exactly one cycle after the address.
module ca_pred_track #(
    parameter int XW = 5,
    parameter int YW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] req_x,
    input  logic [YW-1:0] req_y,
    output logic          hit
);

    logic [XW-1:0] pend_x;
    logic [YW-1:0] pend_y;
    logic          pend_ok;

    // Record the coordinate whose data arrives next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_x  <= '0;
            pend_y  <= '0;
            pend_ok <= 1'b0;
        end else begin
            pend_x  <= req_x;
            pend_y  <= req_y;
            pend_ok <= 1'b1;
        end
    end

    // The returned bit belongs to this pixel only if the prediction matched
    assign hit = pend_ok && (pend_x == cur_x) && (pend_y == cur_y);

endmodule

// File: rtl/ca_hue_lut.sv
// Constant hue wheel of 2^HUE_BITS entries, evenly spaced over six sectors,
// each channel CW bits wide. Entries are computed during elaboration.
// Assumes: HUE_BITS >= 1.
module ca_hue_lut #(
    parameter int HUE_BITS = 2,
    parameter int CW       = 4
) (
    input  logic [HUE_BITS-1:0] idx,
    output logic [CW-1:0]       hue_r,
    output logic [CW-1:0]       hue_g,
    output logic [CW-1:0]       hue_b
);

    localparam int N = 1 << HUE_BITS;
    localparam int M = (1 << CW) - 1;

    logic [3*CW-1:0] wheel [N];

    // One entry per index: sector and fraction around the wheel
    for (genvar i = 0; i < N; i++) begin : g_entry
        localparam int H  = (i * 6 * M) / N;
        localparam int S  = H / M;
        localparam int F  = H % M;
        localparam int RV = (S == 0 || S == 5) ? M : (S == 1) ? M - F : (S == 4) ? F : 0;
        localparam int GV = (S == 0) ? F : (S == 1 || S == 2) ? M : (S == 3) ? M - F : 0;
        localparam int BV = (S == 2) ? F : (S == 3 || S == 4) ? M : (S == 5) ? M - F : 0;
        assign wheel[i] = {CW'(RV), CW'(GV), CW'(BV)};
    end

    // Select the entry for this generation
    assign {hue_r, hue_g, hue_b} = wheel[idx];

endmodule

// File: rtl/ca_colour_stage.sv
// Output register of the pixel pipeline: loads the hue for a visible live
// pixel, black otherwise. This is the single edge between coordinate and colour.
// Assumes: the inputs are settled one cycle after the coordinate changes.
module ca_colour_stage #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          show,
    input  logic [CW-1:0] hue_r,
    input  logic [CW-1:0] hue_g,
    input  logic [CW-1:0] hue_b,
    output logic [CW-1:0] out_r,
    output logic [CW-1:0] out_g,
    output logic [CW-1:0] out_b
);

    // Register this cycle's colour for the timing generator
    always_ff @(posedge clk) begin
        if (!rst_n || !show) begin
            out_r <= '0;
            out_g <= '0;
            out_b <= '0;
        end else begin
            out_r <= hue_r;
            out_g <= hue_g;
            out_b <= hue_b;
        end
    end

endmodule

// File: rtl/ca_pixel_fetch.sv
// Pixel fetch between a raster timing generator and a one-bit-per-cell frame
// memory. Coordinates in cycle n give a colour on the outputs in cycle n+1.
// Direct mode expects a combinational memory; ahead mode prefetches the raster
// successor for a memory with one cycle of read latency and blanks mispredicted pixels.
// Assumes: H_TOTAL >= COLS, V_TOTAL >= ROWS, HUE_BITS <= YW.
module ca_pixel_fetch #(
    parameter int COLS     = 16,
    parameter int ROWS     = 12,
    parameter int H_TOTAL  = 20,
    parameter int V_TOTAL  = 15,
    parameter int XW       = $clog2(H_TOTAL),
    parameter int YW       = $clog2(V_TOTAL),
    parameter int AW       = $clog2(COLS * ROWS),
    parameter int HUE_BITS = 2,
    parameter int CW       = 4,
    parameter ca_fetch_pkg::fetch_mode_e MODE = ca_fetch_pkg::FETCH_DIRECT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_data,
    output logic [CW-1:0] red,
    output logic [CW-1:0] green,
    output logic [CW-1:0] blue
);

    logic          active;
    logic          hit;
    logic          show;
    logic [CW-1:0] hue_r;
    logic [CW-1:0] hue_g;
    logic [CW-1:0] hue_b;

    // Visible picture test for the current coordinate
    assign active = (int'(pix_x) < COLS) && (int'(pix_y) < ROWS);

    if (MODE == ca_fetch_pkg::FETCH_AHEAD) begin : g_ahead
        logic [XW-1:0] nx;
        logic [YW-1:0] ny;

        ca_raster_next #(
            .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .XW(XW), .YW(YW)
        ) u_next (
            .cur_x(pix_x), .cur_y(pix_y), .nxt_x(nx), .nxt_y(ny)
        );

        ca_row_addr #(
            .COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW), .AW(AW)
        ) u_addr (
            .at_x(nx), .at_y(ny), .addr(mem_addr)
        );

        ca_pred_track #(
            .XW(XW), .YW(YW)
        ) u_track (
            .clk(clk), .rst_n(rst_n),
            .cur_x(pix_x), .cur_y(pix_y),
            .req_x(nx), .req_y(ny),
            .hit(hit)
        );
    end else begin : g_direct
        ca_row_addr #(
            .COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW), .AW(AW)
        ) u_addr (
            .at_x(pix_x), .at_y(pix_y), .addr(mem_addr)
        );

        assign hit = 1'b1;
    end

    ca_hue_lut #(
        .HUE_BITS(HUE_BITS), .CW(CW)
    ) u_hue (
        .idx(pix_y[HUE_BITS-1:0]),
        .hue_r(hue_r), .hue_g(hue_g), .hue_b(hue_b)
    );

    // Pixel is lit only when visible, its fetched bit is valid, and the cell lives
    assign show = active && hit && mem_data;

    ca_colour_stage #(
        .CW(CW)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .show(show),
        .hue_r(hue_r), .hue_g(hue_g), .hue_b(hue_b),
        .out_r(red), .out_g(green), .out_b(blue)
    );

endmodule

// File: rtl/ca_pixel_fetch_chk.sv
// Property checker for ca_pixel_fetch, attached by bind. It observes the ports only.
// Assumes: the same parameter values as the bound instance.
module ca_pixel_fetch_chk #(
    parameter int COLS     = 16,
    parameter int ROWS     = 12,
    parameter int H_TOTAL  = 20,
    parameter int V_TOTAL  = 15,
    parameter int XW       = 5,
    parameter int YW       = 4,
    parameter int AW       = 8,
    parameter int CW       = 4,
    parameter ca_fetch_pkg::fetch_mode_e MODE = ca_fetch_pkg::FETCH_DIRECT
) (
    input logic          clk,
    input logic          rst_n,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] pix_y,
    input logic [AW-1:0] mem_addr,
    input logic          mem_data,
    input logic [CW-1:0] red,
    input logic [CW-1:0] green,
    input logic [CW-1:0] blue
);

    logic          vis;
    logic [XW-1:0] prev_x;
    logic [YW-1:0] prev_y;
    logic          prev_ok;
    logic          in_seq;

    assign vis = (int'(pix_x) < COLS) && (int'(pix_y) < ROWS);

    // Remember the last coordinate so raster continuity can be judged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_x  <= '0;
            prev_y  <= '0;
            prev_ok <= 1'b0;
        end else begin
            prev_x  <= pix_x;
            prev_y  <= pix_y;
            prev_ok <= 1'b1;
        end
    end

    // Is the current coordinate the raster step after the previous one
    always_comb begin
        if (int'(prev_x) == H_TOTAL - 1) begin
            in_seq = (pix_x == '0) &&
                     ((int'(prev_y) == V_TOTAL - 1) ? (pix_y == '0) : (int'(pix_y) == int'(prev_y) + 1));
        end else begin
            in_seq = (int'(pix_x) == int'(prev_x) + 1) && (pix_y == prev_y);
        end
    end

    AST_RESET_BLACK: assert property (@(posedge clk) !rst_n |=> (red == '0 && green == '0 && blue == '0)); // R1

    AST_OFFSCREEN_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !vis |=> (red == '0 && green == '0 && blue == '0)); // R4

    AST_DEAD_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (vis && !mem_data) |=> (red == '0 && green == '0 && blue == '0)); // R5

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mem_addr) < COLS * ROWS); // R9

    if (MODE == ca_fetch_pkg::FETCH_AHEAD) begin : g_ahead_chk
        AST_MISS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
            (prev_ok && !in_seq) |=> (red == '0 && green == '0 && blue == '0)); // R8
    end else begin : g_direct_chk
        AST_LIVE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            (vis && mem_data) |=> (red != '0 || green != '0 || blue != '0)); // R6
    end

endmodule

bind ca_pixel_fetch ca_pixel_fetch_chk #(
    .COLS(COLS), .ROWS(ROWS), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .XW(XW), .YW(YW), .AW(AW), .CW(CW), .MODE(MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .red(red), .green(green), .blue(blue)
);

// File: tb/sim_ca_pixel_fetch.sv
// Bench for ca_pixel_fetch: u0 in direct mode with a combinational memory,
// u1 in ahead mode with a registered memory. A behavioural model predicts
// every address and every colour, and both are compared on every clock.
module sim_ca_pixel_fetch;

    localparam int COLS = 16;
    localparam int ROWS = 12;
    localparam int HT   = 20;
    localparam int VT   = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] px = '0;
    logic [3:0] py = '0;
    logic [7:0] addr0, addr1;
    logic       md0;
    logic       md1 = 1'b0;
    logic [3:0] r0, g0, b0, r1, g1, b1;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    function automatic logic cell_at(int a);
        return ((a * 5 + a / 7) % 3) != 0;
    endfunction

    assign md0 = cell_at(int'(addr0));

    // Frame memory for the ahead copy: one cycle of read latency
    always @(posedge clk) md1 <= cell_at(int'(addr1));

    ca_pixel_fetch #(.MODE(ca_fetch_pkg::FETCH_DIRECT)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_x(px), .pix_y(py),
        .mem_addr(addr0), .mem_data(md0), .red(r0), .green(g0), .blue(b0)
    );

    ca_pixel_fetch #(.MODE(ca_fetch_pkg::FETCH_AHEAD)) u1 (
        .clk(clk), .rst_n(rst_n), .pix_x(px), .pix_y(py),
        .mem_addr(addr1), .mem_data(md1), .red(r1), .green(g1), .blue(b1)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Hue wheel with HUE_BITS=2, CW=4 (R6)
    function automatic int hue_of(int y);
        case (y % 4)
            0:       return 'hF00;
            1:       return 'h8F0;
            2:       return 'h0FF;
            default: return 'h70F;
        endcase
    endfunction

    function automatic bit on_screen(int x, int y);
        return x < COLS && y < ROWS;
    endfunction

    function automatic int colour_of(int x, int y, output string tag);
        if (!on_screen(x, y)) begin tag = "R4"; return 0; end
        if (!cell_at(y * COLS + x)) begin tag = "R5"; return 0; end
        tag = "R6";
        return hue_of(y);
    endfunction

    bit    pend = 0;
    int    e0, e1;
    string t0, t1;
    bit    prev_ok = 0;
    int    prev_x, prev_y;

    task automatic step(int x, int y);
        int sx, sy, ex, ey, ea;
        bit hit;
        string t;
        @(negedge clk);
        if (pend) begin
            check({"R2 u0 ", t0}, int'({r0, g0, b0}), e0);
            check({"R2 u1 ", t1}, int'({r1, g1, b1}), e1);
        end
        px = 5'(x);
        py = 4'(y);
        #1;
        check("R3 u0 address", int'(addr0), on_screen(x, y) ? y * COLS + x : 0);
        check("R9 u0 range", int'(addr0 < 8'(COLS * ROWS)), 1);
        check("R9 u1 range", int'(addr1 < 8'(COLS * ROWS)), 1);
        if (x == HT - 1) begin
            sx = 0;
            sy = (y == VT - 1) ? 0 : y + 1;
        end else begin
            sx = x + 1;
            sy = y;
        end
        ea = on_screen(sx, sy) ? sy * COLS + sx : 0;
        check("R7 u1 successor address", int'(addr1), ea);
        e0 = colour_of(x, y, t0);
        if (prev_x == HT - 1) begin
            ex = 0;
            ey = (prev_y == VT - 1) ? 0 : prev_y + 1;
        end else begin
            ex = prev_x + 1;
            ey = prev_y;
        end
        hit = prev_ok && ex == x && ey == y;
        if (hit) begin
            e1 = colour_of(x, y, t);
            t1 = {"R7 ", t};
        end else begin
            e1 = 0;
            t1 = "R8 miss";
        end
        prev_x  = x;
        prev_y  = y;
        prev_ok = 1;
        pend    = 1;
    endtask

    task automatic scan(int count, int x0, int y0);
        int x = x0;
        int y = y0;
        for (int i = 0; i < count; i++) begin
            step(x, y);
            if (x == HT - 1) begin
                x = 0;
                y = (y == VT - 1) ? 0 : y + 1;
            end else begin
                x = x + 1;
            end
        end
    endtask

    task automatic do_reset(int hold_x, int hold_y);
        @(negedge clk);
        if (pend) begin
            check({"R2 u0 ", t0}, int'({r0, g0, b0}), e0);
            check({"R2 u1 ", t1}, int'({r1, g1, b1}), e1);
        end
        rst_n = 1'b0;
        px = 5'(hold_x);
        py = 4'(hold_y);
        repeat (2) @(negedge clk);
        check("R1 u0 black in reset", int'({r0, g0, b0}), 0);
        check("R1 u1 black in reset", int'({r1, g1, b1}), 0);
        rst_n   = 1'b1;
        pend    = 0;
        prev_ok = 0;
    endtask

    initial begin : main
        do_reset(0, 0);
        scan(2 * HT * VT, 0, 0);
        for (int i = 0; i < 150; i++) begin
            step($urandom_range(0, HT - 1), $urandom_range(0, VT - 1));
        end
        do_reset(3, 1);
        scan(120, 3, 1);
        step(0, 0);
        @(negedge clk);
        check({"R2 u0 ", t0}, int'({r0, g0, b0}), e0);
        check({"R2 u1 ", t1}, int'({r1, g1, b1}), e1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        #(4 * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule